// File: doc/BRIEF.md
# Branch-Likely Delay Slot Controller

This block resolves conditional branches at decode for an in-order core whose branches carry one architectural delay slot. Each cycle it sees at most one instruction word together with its PC and the two source operand values already read from the register file. For a branch it reports whether the branch is taken, where fetch continues, and whether the instruction in the delay slot must be cancelled. It handles the equality branches in two flavours: ordinary branches, whose slot always runs, and branch-likely forms, whose slot runs only when the branch is taken.

A branch-likely that falls through squashes its slot and sends fetch to the branch PC plus 8. The block remembers this until the slot instruction arrives, then marks that instruction cancelled, withholding its retire so that it makes no register write, memory access or trap. A taken branch of either flavour lets its slot run and supplies the branch target as the slot's successor PC. The cancel condition is an OR of one not-taken term per likely opcode, so more likely variants only add a row to a table.

Cycles with no valid instruction leave the pending slot state untouched, so the slot may arrive any number of cycles after its branch.

Top module: `branch_likely_unit`

## Requirements
- R1: Instruction fields are opcode = instr[31:26], rs = instr[25:21], rt = instr[20:16], offset = instr[15:0]. Opcodes 6'h04 (branch-if-equal), 6'h05 (branch-if-not-equal), 6'h14 (equal, likely) and 6'h15 (not-equal, likely) are branches; any other opcode gives br_taken = 0, squash_slot = 0 and next_pc = pc + 4.
- R2: br_taken is 1 for a live 6'h04 or 6'h14 when rs_val == rt_val, and for a live 6'h05 or 6'h15 when rs_val != rt_val; otherwise 0.
- R3: squash_slot is 1 exactly for a live 6'h14 with rs_val != rt_val or a live 6'h15 with rs_val == rt_val; ordinary branches never raise it.
- R4: A live instruction that raises squash_slot has next_pc = pc + 8; any other live instruction that is not a slot of a taken branch has next_pc = pc + 4.
- R5: The next valid instruction after a taken branch (its delay slot) is not cancelled, retires, and has next_pc = branch PC + 4 + (sign-extended offset << 2).
- R6: The next valid instruction after a squashing branch has slot_cancel = 1, retire = 0, br_taken = 0 and squash_slot = 0, even when it is itself a branch encoding.
- R7: Every valid instruction that is not cancelled retires, including the slot of a not-taken ordinary branch; a squashing branch itself retires once.
- R8: Cycles with instr_valid = 0 drive retire, slot_cancel, br_taken and squash_slot low and do not consume the pending slot state.
- R9: After reset no slot is pending: the first valid instruction is not cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| pc | input | XLEN | Address of the presented instruction |
| rs_val | input | XLEN | Value of the first source register |
| rt_val | input | XLEN | Value of the second source register |
| br_taken | output | 1 | Branch resolved as taken |
| squash_slot | output | 1 | Branch-likely fell through; its slot is to be cancelled |
| next_pc | output | XLEN | Fetch address following this instruction |
| slot_cancel | output | 1 | This instruction is a cancelled delay slot |
| retire | output | 1 | This instruction counts as retired and may commit |

## Verification
A wrong pending-cancel bit shows on the very next valid instruction: either a fall-through likely branch lets its slot retire, or an unrelated instruction loses its retire with slot_cancel raised. A lost or stale pending target appears as a wrong next_pc on the slot instruction, one valid instruction after the branch. A wrong compare polarity or opcode table shows in the same cycle as the branch, on br_taken, squash_slot and next_pc together.

// File: rtl/brl_pkg.sv
package brl_pkg;

  localparam int INSTR_W  = 32;
  localparam int OPC_W    = 6;
  localparam int OFF_W    = 16;
  localparam int OPC_LSB  = 26;

  localparam logic [OPC_W-1:0] OPC_BR_EQ    = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BR_NE    = 6'h05;
  localparam logic [OPC_W-1:0] OPC_BR_EQ_LK = 6'h14;
  localparam logic [OPC_W-1:0] OPC_BR_NE_LK = 6'h15;

  // Table of likely opcodes: each row adds one not-taken term to the cancel OR.
  localparam int LIKELY_N = 2;
  localparam logic [LIKELY_N-1:0][OPC_W-1:0] LIKELY_OPC = {OPC_BR_NE_LK, OPC_BR_EQ_LK};
  localparam logic [LIKELY_N-1:0]            LIKELY_EQ  = 2'b01; // row0 wants equal

  typedef struct packed {
    logic is_branch;
    logic is_likely;
    logic want_equal;
  } br_class_t;

  function automatic br_class_t classify(input logic [OPC_W-1:0] opc);
    br_class_t c;
    c = '0;
    unique case (opc)
      OPC_BR_EQ:    c = '{is_branch: 1'b1, is_likely: 1'b0, want_equal: 1'b1};
      OPC_BR_NE:    c = '{is_branch: 1'b1, is_likely: 1'b0, want_equal: 1'b0};
      OPC_BR_EQ_LK: c = '{is_branch: 1'b1, is_likely: 1'b1, want_equal: 1'b1};
      OPC_BR_NE_LK: c = '{is_branch: 1'b1, is_likely: 1'b1, want_equal: 1'b0};
      default:      c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/brl_decode.sv
module brl_decode
  import brl_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output logic [OPC_W-1:0]   opcode,
  output logic [OFF_W-1:0]   offset,
  output br_class_t          cls
);
  assign opcode = instr[OPC_LSB +: OPC_W];
  assign offset = instr[OFF_W-1:0];
  assign cls    = classify(opcode);
endmodule

// File: rtl/brl_likely_squash.sv
module brl_likely_squash
  import brl_pkg::*;
(
  input  logic             live,
  input  logic [OPC_W-1:0] opcode,
  input  logic             ops_equal,
  output logic             squash
);
  logic [LIKELY_N-1:0] term;

  // One not-taken term per likely opcode, ORed together.
  for (genvar g = 0; g < LIKELY_N; g++) begin : g_term
    assign term[g] = live && (opcode == LIKELY_OPC[g]) && (ops_equal != LIKELY_EQ[g]);
  end

  assign squash = |term;
endmodule

// File: rtl/brl_pc_calc.sv
module brl_pc_calc
  import brl_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [OFF_W-1:0] offset,
  output logic [XLEN-1:0]  seq_pc,
  output logic [XLEN-1:0]  skip_pc,
  output logic [XLEN-1:0]  target_pc
);
  localparam int EXT_W = XLEN - OFF_W - 2;

  function automatic logic [XLEN-1:0] step(input logic [XLEN-1:0] a, input int words);
    return a + XLEN'(words * 4);
  endfunction

  function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] a,
                                                  input logic [OFF_W-1:0] off);
    return step(a, 1) + {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
  endfunction

  assign seq_pc    = step(pc, 1);
  assign skip_pc   = step(pc, 2);
  assign target_pc = branch_dest(pc, offset);
endmodule

// File: rtl/brl_slot_state.sv
module brl_slot_state #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic            set_kill,
  input  logic            set_redirect,
  input  logic [XLEN-1:0] target_in,
  output logic            kill_q,
  output logic            redirect_q,
  output logic [XLEN-1:0] target_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kill_q     <= 1'b0;
      redirect_q <= 1'b0;
      target_q   <= '0;
    end else if (advance) begin
      kill_q     <= set_kill;
      redirect_q <= set_redirect;
      target_q   <= target_in;
    end
  end
endmodule

// File: rtl/branch_likely_unit.sv
module branch_likely_unit
  import brl_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [XLEN-1:0]    pc,
  input  logic [XLEN-1:0]    rs_val,
  input  logic [XLEN-1:0]    rt_val,
  output logic               br_taken,
  output logic               squash_slot,
  output logic [XLEN-1:0]    next_pc,
  output logic               slot_cancel,
  output logic               retire
);
  logic [OPC_W-1:0] opcode;
  logic [OFF_W-1:0] offset;
  br_class_t        cls;
  logic             ops_equal;
  logic             live;
  logic             kill_q;
  logic             redirect_q;
  logic [XLEN-1:0]  target_q;
  logic [XLEN-1:0]  seq_pc;
  logic [XLEN-1:0]  skip_pc;
  logic [XLEN-1:0]  target_pc;

  brl_decode u_decode (
    .instr  (instr),
    .opcode (opcode),
    .offset (offset),
    .cls    (cls)
  );

  brl_pc_calc #(.XLEN(XLEN)) u_pc (
    .pc        (pc),
    .offset    (offset),
    .seq_pc    (seq_pc),
    .skip_pc   (skip_pc),
    .target_pc (target_pc)
  );

  assign ops_equal   = (rs_val == rt_val);
  assign live        = instr_valid && !kill_q;
  assign slot_cancel = instr_valid && kill_q;
  assign retire      = live;
  assign br_taken    = live && cls.is_branch && (ops_equal == cls.want_equal);

  brl_likely_squash u_squash (
    .live      (live),
    .opcode    (opcode),
    .ops_equal (ops_equal),
    .squash    (squash_slot)
  );

  brl_slot_state #(.XLEN(XLEN)) u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .advance      (instr_valid),
    .set_kill     (squash_slot),
    .set_redirect (br_taken),
    .target_in    (target_pc),
    .kill_q       (kill_q),
    .redirect_q   (redirect_q),
    .target_q     (target_q)
  );

  always_comb begin
    if (redirect_q)       next_pc = target_q;
    else if (squash_slot) next_pc = skip_pc;
    else                  next_pc = seq_pc;
  end
endmodule

// File: rtl/brl_checker.sv
module brl_checker
  import brl_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               instr_valid,
  input logic [INSTR_W-1:0] instr,
  input logic [XLEN-1:0]    pc,
  input logic [XLEN-1:0]    rs_val,
  input logic [XLEN-1:0]    rt_val,
  input logic               br_taken,
  input logic               squash_slot,
  input logic [XLEN-1:0]    next_pc,
  input logic               slot_cancel,
  input logic               retire
);
  localparam int EXT_W = XLEN - OFF_W - 2;

  logic [OPC_W-1:0] c_opc;
  logic             c_eq;
  logic             pend_kill;
  logic             pend_redir;
  logic [XLEN-1:0]  pend_tgt;

  assign c_opc = instr[INSTR_W-1 -: OPC_W];
  assign c_eq  = (rs_val == rt_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_kill  <= 1'b0;
      pend_redir <= 1'b0;
      pend_tgt   <= '0;
    end else if (instr_valid) begin
      pend_kill  <= squash_slot;
      pend_redir <= br_taken;
      pend_tgt   <= pc + XLEN'(4) + {{EXT_W{instr[OFF_W-1]}}, instr[OFF_W-1:0], 2'b00};
    end
  end

  assert_taken_cond_R2: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> ((c_opc == 6'h04 || c_opc == 6'h14) && c_eq) ||
                 ((c_opc == 6'h05 || c_opc == 6'h15) && !c_eq));

  assert_squash_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    squash_slot |-> (c_opc == 6'h14 && !c_eq) || (c_opc == 6'h15 && c_eq));

  assert_squash_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    squash_slot |-> (next_pc == pc + XLEN'(8)) && !br_taken);

  assert_slot_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && pend_redir) |-> (next_pc == pend_tgt) && retire && !slot_cancel);

  assert_slot_cancel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && pend_kill) |-> slot_cancel && !retire);

  assert_cancel_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_cancel |-> !br_taken && !squash_slot && !retire);

  assert_retire_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !slot_cancel) |-> retire);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> !retire && !slot_cancel && !br_taken && !squash_slot);
endmodule

bind branch_likely_unit brl_checker #(.XLEN(XLEN)) u_brl_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .instr       (instr),
  .pc          (pc),
  .rs_val      (rs_val),
  .rt_val      (rt_val),
  .br_taken    (br_taken),
  .squash_slot (squash_slot),
  .next_pc     (next_pc),
  .slot_cancel (slot_cancel),
  .retire      (retire)
);

// File: tb/test_branch_likely_unit.sv
module test_branch_likely_unit;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            instr_valid = 1'b0;
  logic [31:0]     instr = '0;
  logic [XLEN-1:0] pc = '0;
  logic [XLEN-1:0] rs_val = '0;
  logic [XLEN-1:0] rt_val = '0;
  logic            br_taken, squash_slot, slot_cancel, retire;
  logic [XLEN-1:0] next_pc;

  int checks = 0;
  int failures = 0;
  logic [31:0] sentinel;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_likely_unit #(.XLEN(XLEN)) i_branch_likely_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr), .pc(pc),
    .rs_val(rs_val), .rt_val(rt_val), .br_taken(br_taken), .squash_slot(squash_slot),
    .next_pc(next_pc), .slot_cancel(slot_cancel), .retire(retire)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [15:0] off);
    return {opc, 5'd8, 5'd9, off};
  endfunction

  // Drive on the falling edge, outputs settle before the next rising edge.
  task automatic present(input logic v, input logic [31:0] w, input logic [31:0] a,
                         input logic [31:0] s, input logic [31:0] t);
    @(negedge clk);
    instr_valid = v; instr = w; pc = a; rs_val = s; rt_val = t;
    #1;
  endtask

  // Slot instruction: writes a sentinel only if it retires (commit gate).
  task automatic slot_step(input logic [31:0] a, input logic [31:0] val);
    present(1'b1, mk(6'h0D, 16'h0001), a, 32'h0, 32'h0);
    if (retire) sentinel = val;
  endtask

  // Branch followed by its delay slot; expectations from the requirement text.
  task automatic run_branch(input string name, input logic [5:0] opc, input logic [31:0] a,
                            input logic [31:0] s, input logic [31:0] t, input logic [15:0] off);
    logic likely, eqw, take, sq;
    logic [31:0] tgt;
    likely = (opc == 6'h14) || (opc == 6'h15);
    eqw    = (opc == 6'h04) || (opc == 6'h14);
    take   = (s == t) == eqw;
    sq     = likely && !take;
    tgt    = a + 32'd4 + {{14{off[15]}}, off, 2'b00};
    sentinel = 32'hBEEF0000;
    present(1'b1, mk(opc, off), a, s, t);
    chk({name, " R2 taken"}, {31'b0, br_taken}, {31'b0, take});
    chk({name, " R3 squash"}, {31'b0, squash_slot}, {31'b0, sq});
    chk({name, " R4 npc"}, next_pc, sq ? a + 32'd8 : a + 32'd4);
    chk({name, " R7 branch retires"}, {31'b0, retire}, 32'd1);
    slot_step(a + 32'd4, 32'hBABE0CAB);
    chk({name, " R6 slot cancel"}, {31'b0, slot_cancel}, {31'b0, sq});
    chk({name, " R7 slot retire"}, {31'b0, retire}, {31'b0, !sq});
    chk({name, " R5/R6 sentinel"}, sentinel, sq ? 32'hBEEF0000 : 32'hBABE0CAB);
    if (take) chk({name, " R5 slot npc"}, next_pc, tgt);
    else      chk({name, " R4 slot npc"}, next_pc, a + 32'd8);
  endtask

  task automatic t_reset;
    present(1'b0, 32'h0, 32'h0, 32'h0, 32'h0);
    chk("R8 idle retire", {31'b0, retire}, 32'd0);
    present(1'b1, mk(6'h00, 16'h0), 32'h0000_0100, 32'h1, 32'h1);
    chk("R9 first not cancelled", {31'b0, slot_cancel}, 32'd0);
    chk("R9 first retires", {31'b0, retire}, 32'd1);
    chk("R1 nonbranch npc", next_pc, 32'h0000_0104);
  endtask

  task automatic t_nonbranch;
    present(1'b1, mk(6'h16, 16'h0008), 32'h0000_0200, 32'h3, 32'h3);
    chk("R1 op16 taken", {31'b0, br_taken}, 32'd0);
    chk("R1 op16 squash", {31'b0, squash_slot}, 32'd0);
    chk("R1 op16 npc", next_pc, 32'h0000_0204);
    present(1'b1, mk(6'h06, 16'h0008), 32'h0000_0204, 32'h3, 32'h4);
    chk("R1 op06 taken", {31'b0, br_taken}, 32'd0);
    chk("R1 op06 squash", {31'b0, squash_slot}, 32'd0);
  endtask

  task automatic t_slot_is_branch;
    present(1'b1, mk(6'h14, 16'h0004), 32'h0000_3000, 32'h1, 32'h2);
    chk("R3 beql squash", {31'b0, squash_slot}, 32'd1);
    present(1'b1, mk(6'h04, 16'h0010), 32'h0000_3004, 32'h5, 32'h5);
    chk("R6 slot branch taken", {31'b0, br_taken}, 32'd0);
    chk("R6 slot branch squash", {31'b0, squash_slot}, 32'd0);
    chk("R6 slot branch cancel", {31'b0, slot_cancel}, 32'd1);
    present(1'b1, mk(6'h00, 16'h0), 32'h0000_3008, 32'h0, 32'h0);
    chk("R6 after slot clean", {31'b0, slot_cancel}, 32'd0);
    chk("R4 after slot npc", next_pc, 32'h0000_300C);
  endtask

  task automatic t_gap;
    present(1'b1, mk(6'h15, 16'h0004), 32'h0000_4000, 32'h9, 32'h9);
    chk("R3 bnel squash", {31'b0, squash_slot}, 32'd1);
    present(1'b0, mk(6'h15, 16'h0004), 32'h0000_4004, 32'h9, 32'h9);
    chk("R8 gap retire", {31'b0, retire}, 32'd0);
    chk("R8 gap cancel", {31'b0, slot_cancel}, 32'd0);
    chk("R8 gap squash", {31'b0, squash_slot}, 32'd0);
    present(1'b0, 32'h0, 32'h0000_4004, 32'h0, 32'h0);
    present(1'b1, mk(6'h00, 16'h0), 32'h0000_4004, 32'h0, 32'h0);
    chk("R8 pending kept", {31'b0, slot_cancel}, 32'd1);
    chk("R8 pending retire", {31'b0, retire}, 32'd0);
  endtask

  task automatic t_taken_gap;
    present(1'b1, mk(6'h05, 16'h0020), 32'h0000_5000, 32'h1, 32'h2);
    present(1'b0, 32'h0, 32'h0, 32'h0, 32'h0);
    present(1'b1, mk(6'h00, 16'h0), 32'h0000_5004, 32'h0, 32'h0);
    chk("R5 target after gap", next_pc, 32'h0000_5084);
    chk("R5 slot retires", {31'b0, retire}, 32'd1);
  endtask

  initial begin
    sentinel = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_nonbranch();
    run_branch("bnel_taken",  6'h15, 32'h0000_1000, 32'd5, 32'd7, 16'h0010);
    run_branch("bnel_nottkn", 6'h15, 32'h0000_1100, 32'd3, 32'd3, 16'h0010);
    run_branch("bne_nottkn",  6'h05, 32'h0000_1200, 32'd3, 32'd3, 16'h0010);
    run_branch("bne_taken",   6'h05, 32'h0000_1300, 32'd1, 32'd2, 16'hFFFE);
    run_branch("beql_taken",  6'h14, 32'h0000_1400, 32'd4, 32'd4, 16'hFFF0);
    run_branch("beql_nottkn", 6'h14, 32'h0000_1500, 32'd4, 32'd6, 16'h0010);
    run_branch("beq_taken",   6'h04, 32'h0000_1600, 32'd8, 32'd8, 16'h0003);
    run_branch("beq_nottkn",  6'h04, 32'h0000_1700, 32'd8, 32'd9, 16'h0003);
    t_slot_is_branch();
    t_gap();
    t_taken_gap();
    present(1'b0, 32'h0, 32'h0, 32'h0, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule